// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block sits on the host side of a parallel NOR-style flash bus. It takes one request at a time: either program one half-word at a given address, or erase the whole chip. It then writes the unlock and command pattern that the flash expects, one bus write per clock. After the final command write it polls the target address at a fixed interval and watches data bit 7 to see when the flash's internal algorithm has finished.

A program operation is finished when polled bit 7 equals bit 7 of the data that was written. A chip erase is finished when polled bit 7 reads as 1. A limit on the number of failed polls comes from an input port. When that limit is used up, the sequencer writes the reset command 0xF0 to the target address and reports an error.

Requests are taken with a valid/ready handshake. Each request ends with a one-cycle done pulse, and an error bit is qualified by that pulse. Reads are single-cycle strobes, and the flash returns the data in the following cycle.

Top module: `flash_seq_top`

## Requirements
- R1: After reset, req_ready is 1 and bus_we, bus_re and done are 0.
- R2: A program request (req_erase=0) produces exactly four bus writes, given as (address, data): (0x555, 0x00AA), (0x2AA, 0x0055), (0x555, 0x00A0), then (req_addr, req_data).
- R3: A chip-erase request (req_erase=1) produces exactly six bus writes: (0x555, 0x00AA), (0x2AA, 0x0055), (0x555, 0x0080), (0x555, 0x00AA), (0x2AA, 0x0055), (0x555, 0x0010).
- R4: Command writes occupy consecutive cycles. The first one is driven in the cycle after the clock edge that accepts the request, and bus_we and bus_re are never high together.
- R5: req_ready is low from acceptance until the done pulse. A req_valid raised in that time has no effect: it causes no bus activity and no extra operation.
- R6: Poll reads go to the request address. The first read comes POLL_GAP+1 cycles after the last command write, and each later read comes POLL_GAP+2 cycles after the previous one. bus_rdata is taken in the cycle after bus_re.
- R7: A program operation completes without error on the first poll whose bit 7 equals bit 7 of req_data.
- R8: A chip-erase operation completes without error on the first poll whose bit 7 is 1.
- R9: If timeout_limit consecutive polls all fail (a limit of 0 behaves as 1), the block writes (req_addr, 0x00F0) two cycles after the last read and raises done with error=1 one cycle later.
- R10: done is a single-cycle pulse, and error is high only together with done. On success, done is high two cycles after the final poll read and error is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_erase | input | 1 | 1 = chip erase, 0 = half-word program |
| req_addr | input | AW | Target/poll address |
| req_data | input | DW | Data to program |
| timeout_limit | input | TW | Maximum failed polls before abort |
| bus_we | output | 1 | Flash write strobe |
| bus_re | output | 1 | Flash read strobe |
| bus_addr | output | AW | Flash address |
| bus_wdata | output | DW | Flash write data |
| bus_rdata | input | DW | Flash read data, valid the cycle after bus_re |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Timeout indication, valid with done |

## Verification
A wrong step counter or command selection shows up at once as an out-of-order or misplaced bus write, within the four or six cycles after acceptance. A broken gap or fail counter moves the poll read strobe off its expected cycle, or changes the number of reads before the abort write, at the very first poll. A faulty completion decision shows as a done pulse one poll too early or too late, or as a wrong error bit, no later than one poll interval after the flash reports ready.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_WAIT,
    S_READ,
    S_CHECK,
    S_ABORT,
    S_FIN
  } seq_state_e;

  localparam logic [11:0] UNLK_ADDR_A = 12'h555;
  localparam logic [11:0] UNLK_ADDR_B = 12'h2AA;
  localparam logic [7:0]  UNLK_DATA_A = 8'hAA;
  localparam logic [7:0]  UNLK_DATA_B = 8'h55;
  localparam logic [7:0]  CODE_PROG   = 8'hA0;
  localparam logic [7:0]  CODE_ESETUP = 8'h80;
  localparam logic [7:0]  CODE_CHIP   = 8'h10;
  localparam logic [7:0]  CODE_RESET  = 8'hF0;

  localparam int PROG_STEPS  = 4;
  localparam int ERASE_STEPS = 6;
  localparam int STEP_W      = 3;

endpackage

// File: rtl/flash_cmd_gen.sv
module flash_cmd_gen
  import flash_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic              is_erase,
  input  logic [STEP_W-1:0] step,
  input  logic [AW-1:0]     tgt_addr,
  input  logic [DW-1:0]     tgt_data,
  output logic [AW-1:0]     cmd_addr,
  output logic [DW-1:0]     cmd_data,
  output logic              cmd_last
);

  localparam logic [AW-1:0] A_ONE = AW'(UNLK_ADDR_A);
  localparam logic [AW-1:0] A_TWO = AW'(UNLK_ADDR_B);

  always_comb begin
    cmd_addr = A_ONE;
    cmd_data = DW'(UNLK_DATA_A);
    if (is_erase) begin
      cmd_last = (step == STEP_W'(ERASE_STEPS - 1));
      case (step)
        3'd0: begin cmd_addr = A_ONE; cmd_data = DW'(UNLK_DATA_A); end
        3'd1: begin cmd_addr = A_TWO; cmd_data = DW'(UNLK_DATA_B); end
        3'd2: begin cmd_addr = A_ONE; cmd_data = DW'(CODE_ESETUP); end
        3'd3: begin cmd_addr = A_ONE; cmd_data = DW'(UNLK_DATA_A); end
        3'd4: begin cmd_addr = A_TWO; cmd_data = DW'(UNLK_DATA_B); end
        default: begin cmd_addr = A_ONE; cmd_data = DW'(CODE_CHIP); end
      endcase
    end else begin
      cmd_last = (step == STEP_W'(PROG_STEPS - 1));
      case (step)
        3'd0: begin cmd_addr = A_ONE; cmd_data = DW'(UNLK_DATA_A); end
        3'd1: begin cmd_addr = A_TWO; cmd_data = DW'(UNLK_DATA_B); end
        3'd2: begin cmd_addr = A_ONE; cmd_data = DW'(CODE_PROG); end
        default: begin cmd_addr = tgt_addr; cmd_data = tgt_data; end
      endcase
    end
  end

endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
  parameter int POLL_GAP = 8,
  parameter int TW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gap_run,
  input  logic          fail_inc,
  input  logic          fail_clr,
  input  logic [TW-1:0] limit,
  output logic          gap_hit,
  output logic          limit_last
);

  localparam int GW = (POLL_GAP < 2) ? 1 : $clog2(POLL_GAP);
  localparam logic [GW-1:0] GAP_END = GW'(POLL_GAP - 1);

  logic [GW-1:0] gap_q, gap_d;
  logic [TW-1:0] fail_q, fail_d;
  logic [TW:0]   fail_plus;

  always_comb begin
    gap_d = gap_run ? (gap_q + 1'b1) : '0;
    if (gap_run && gap_q == GAP_END) gap_d = '0;
  end

  always_comb begin
    fail_d = fail_q;
    if (fail_clr)      fail_d = '0;
    else if (fail_inc) fail_d = fail_q + 1'b1;
  end

  assign gap_hit    = gap_run && (gap_q == GAP_END);
  assign fail_plus  = {1'b0, fail_q} + 1'b1;
  assign limit_last = (fail_plus >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      fail_q <= '0;
    end else begin
      gap_q  <= gap_d;
      fail_q <= fail_d;
    end
  end

endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
  import flash_seq_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 16,
  parameter int TW       = 8,
  parameter int POLL_GAP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_erase,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [TW-1:0] timeout_limit,
  output logic          bus_we,
  output logic          bus_re,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          done,
  output logic          error
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              erase_q, err_q, err_d, cap_en;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     data_q;

  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic          cmd_last;
  logic          gap_hit, limit_last, poll_ok, poll_fail;
  logic          rdata_unused;

  assign rdata_unused = ^{bus_rdata[DW-1:8], bus_rdata[6:0]};

  flash_cmd_gen #(.AW(AW), .DW(DW)) u_cmd (
    .is_erase (erase_q),
    .step     (step_q),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .cmd_last (cmd_last)
  );

  flash_poll_timer #(.POLL_GAP(POLL_GAP), .TW(TW)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .gap_run    (state_q == S_WAIT),
    .fail_inc   (poll_fail),
    .fail_clr   (state_q == S_IDLE),
    .limit      (timeout_limit),
    .gap_hit    (gap_hit),
    .limit_last (limit_last)
  );

  assign poll_ok   = erase_q ? bus_rdata[7] : (bus_rdata[7] == data_q[7]);
  assign poll_fail = (state_q == S_CHECK) && !poll_ok;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    err_d   = err_q;
    cap_en  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          step_d  = '0;
          err_d   = 1'b0;
          state_d = S_CMD;
        end
      end
      S_CMD: begin
        if (cmd_last) state_d = S_WAIT;
        else          step_d  = step_q + 1'b1;
      end
      S_WAIT:  if (gap_hit) state_d = S_READ;
      S_READ:  state_d = S_CHECK;
      S_CHECK: begin
        if (poll_ok) begin
          state_d = S_FIN;
        end else if (limit_last) begin
          err_d   = 1'b1;
          state_d = S_ABORT;
        end else begin
          state_d = S_WAIT;
        end
      end
      S_ABORT: state_d = S_FIN;
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      erase_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (cap_en) begin
      erase_q <= req_erase;
      addr_q  <= req_addr;
      data_q  <= req_data;
    end
  end

  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    case (state_q)
      S_CMD: begin
        bus_addr  = cmd_addr;
        bus_wdata = cmd_data;
      end
      S_READ:  bus_addr = addr_q;
      S_ABORT: begin
        bus_addr  = addr_q;
        bus_wdata = DW'(CODE_RESET);
      end
      default: ;
    endcase
  end

  assign req_ready = (state_q == S_IDLE);
  assign bus_we    = (state_q == S_CMD) || (state_q == S_ABORT);
  assign bus_re    = (state_q == S_READ);
  assign done      = (state_q == S_FIN);
  assign error     = done && err_q;

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic bus_we,
  input logic bus_re,
  input logic done,
  input logic error
);

  // R5
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(bus_we || bus_re));

  // R4
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  // R6
  read_then_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> !(bus_re || bus_we || done));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  error_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  // R10
  done_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

endmodule

bind flash_seq_top flash_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .done      (done),
  .error     (error)
);

// File: tb/tb_flash_seq_top.sv
module tb_flash_seq_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int TW = 8;
  localparam int POLL_GAP = 5;

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_erase;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic [TW-1:0] timeout_limit;
  logic          bus_we, bus_re, done, error;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  flash_seq_top #(.AW(AW), .DW(DW), .TW(TW), .POLL_GAP(POLL_GAP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_addr(req_addr), .req_data(req_data),
    .timeout_limit(timeout_limit), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .error(error)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [AW+DW-1:0] exp_wr[$];
  bit               exp_res[$];

  bit            cur_erase;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_data;
  int            cur_busy;
  bit            op_done;
  bit            mon_on = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  // monitor / scoreboard
  initial begin
    int acc_cyc, wr_i, last_wr, last_rd, reads_seen;
    logic [AW+DW-1:0] e;
    bit er;
    acc_cyc = 0; wr_i = 0; last_wr = 0; last_rd = 0; reads_seen = 0;
    forever begin
      @(negedge clk);
      #1;
      if (mon_on) begin
        if (req_valid && req_ready) begin
          acc_cyc = cyc + 1; wr_i = 0; reads_seen = 0;
        end
        if (bus_we) begin
          if (exp_wr.size() == 0) begin
            chk(0, "R5", "unexpected write", {bus_addr, bus_wdata}, 0);
          end else begin
            e = exp_wr.pop_front();
            chk({bus_addr, bus_wdata} == e, cur_erase ? "R3" : "R2",
                "write addr/data", {bus_addr, bus_wdata}, e);
          end
          if (wr_i < (cur_erase ? 6 : 4))
            chk(cyc == acc_cyc + wr_i, "R4", "write cycle", cyc, acc_cyc + wr_i);
          else
            chk(cyc == last_rd + 2, "R9", "abort write cycle", cyc, last_rd + 2);
          last_wr = cyc;
          wr_i++;
        end
        if (bus_re) begin
          chk(bus_addr == cur_addr, "R6", "poll address", bus_addr, cur_addr);
          if (reads_seen == 0)
            chk(cyc == last_wr + POLL_GAP + 1, "R6", "first poll cycle", cyc, last_wr + POLL_GAP + 1);
          else
            chk(cyc == last_rd + POLL_GAP + 2, "R6", "poll spacing", cyc, last_rd + POLL_GAP + 2);
          last_rd = cyc;
          reads_seen++;
          if (reads_seen > cur_busy)
            bus_rdata = cur_erase ? 16'hFFFF : cur_data;
          else
            bus_rdata = cur_erase ? 16'h0000 : (cur_data ^ 16'h0080);
        end
        if (done) begin
          if (exp_res.size() == 0) begin
            chk(0, "R10", "unexpected done", 1, 0);
          end else begin
            er = exp_res.pop_front();
            chk(error == er, er ? "R9" : (cur_erase ? "R8" : "R7"), "error bit", error, er);
            chk(cyc == last_rd + (er ? 3 : 2), er ? "R9" : "R10", "done cycle",
                cyc, last_rd + (er ? 3 : 2));
            chk(reads_seen == (er ? int'(timeout_limit == 0 ? 1 : timeout_limit) : cur_busy + 1),
                er ? "R9" : (cur_erase ? "R8" : "R7"), "poll count", reads_seen,
                er ? (timeout_limit == 0 ? 1 : timeout_limit) : cur_busy + 1);
          end
          op_done = 1;
        end
      end
    end
  end

  // driver
  task automatic run_op(input bit er, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int busy, input int lim, input bit poke);
    bit to;
    int eff;
    cur_erase = er; cur_addr = a; cur_data = d; cur_busy = busy;
    timeout_limit = TW'(lim);
    eff = (lim == 0) ? 1 : lim;
    if (er) begin
      exp_wr.push_back({20'h00555, 16'h00AA});
      exp_wr.push_back({20'h002AA, 16'h0055});
      exp_wr.push_back({20'h00555, 16'h0080});
      exp_wr.push_back({20'h00555, 16'h00AA});
      exp_wr.push_back({20'h002AA, 16'h0055});
      exp_wr.push_back({20'h00555, 16'h0010});
    end else begin
      exp_wr.push_back({20'h00555, 16'h00AA});
      exp_wr.push_back({20'h002AA, 16'h0055});
      exp_wr.push_back({20'h00555, 16'h00A0});
      exp_wr.push_back({a, d});
    end
    to = (busy >= eff);
    if (to) exp_wr.push_back({a, 16'h00F0});
    exp_res.push_back(to);
    op_done = 0;
    @(negedge clk);
    req_erase = er; req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_erase = ~er; req_addr = 20'h0ABCD;
      #1;
      chk(req_ready == 1'b0, "R5", "ready while busy", req_ready, 0);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (4 * POLL_GAP) @(negedge clk);
      #1;
      chk(req_ready == 1'b0, "R5", "ready still low mid-op", req_ready, 0);
    end
    wait (op_done);
    @(negedge clk);
    #2;
    chk(req_ready == 1'b1, "R5", "ready after done", req_ready, 1);
    chk(exp_wr.size() == 0, "R5", "leftover expected writes", exp_wr.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_erase = 1'b0; req_addr = '0;
    req_data = '0; timeout_limit = 8'd8; bus_rdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(bus_we == 1'b0 && bus_re == 1'b0, "R1", "bus idle", {bus_we, bus_re}, 0);
    chk(done == 1'b0, "R1", "done low", done, 0);
    mon_on = 1;
    run_op(1'b0, 20'h12345, 16'hBEEF, 2, 8, 1'b0);   // R7 bit7=1
    run_op(1'b0, 20'h00F00, 16'h0041, 0, 8, 1'b0);   // R7 bit7=0, first poll
    run_op(1'b1, 20'h00010, 16'h0000, 3, 8, 1'b1);   // R8 with ignored request R5
    run_op(1'b0, 20'h54321, 16'h1234, 100, 3, 1'b0); // R9 program timeout
    run_op(1'b1, 20'h00020, 16'h0000, 5, 1, 1'b0);   // R9 erase timeout
    run_op(1'b0, 20'h00777, 16'h00FF, 0, 0, 1'b0);   // R9 limit zero acts as one, success
    run_op(1'b0, 20'h00888, 16'h0080, 4, 0, 1'b0);   // R9 limit zero, timeout
    run_op(1'b0, 20'h0FFFF, 16'h5A5A, 1, 8, 1'b0);   // R7 after error
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule